// File: doc/BRIEF.md
# Boundary-Scan Register Chain with Test-Vector Sequencer

This block places a chain of `N` scan cells between a set of parallel input pins and the matching parallel output pins. Every cell holds two stages. The first is a capture/shift flip-flop, which either samples its pin input or takes part in a serial shift register. The second is an update latch, which holds the value that the cell applies to its pin output in test mode. An output multiplexer picks between the pin input (normal, transparent) and the update latch (test). Because the cell has separate shift and hold stages, the applied test values stay steady on the outputs while new data shifts through the chain.

The raw controls are shift enable, capture enable, update strobe and test mode. They can drive the chain directly from a serial input to a serial output. A small sequencer runs one complete test cycle from a single start pulse. It shifts a parallel test vector in, and in the same shift it gathers the responses captured by the previous cycle. It then loads the update latches, captures the pin inputs, and reports the gathered responses with a one-cycle done pulse. While the sequencer runs, it holds the outputs in test mode and ignores the raw controls.

Top module: `bscan_chain`

## Requirements
- R1: With test_mode at 0, the sequencer idle and reset released, pin_out equals pin_in combinationally.
- R2: With test_mode at 1, or while seq_busy is 1, pin_out equals the update latches and does not depend on pin_in.
- R3: While idle, a rising edge with scan_en at 0 and cap_en at 1 loads pin_in into the capture/shift flip-flops. With both at 0, the flip-flops hold.
- R4: While idle, a rising edge with scan_en at 1 moves every flip-flop one cell toward the serial output, with cell 0 taking si. scan_en takes priority over cap_en. so is always the flip-flop of cell N-1, so a bit entered at si appears on so after exactly N shift edges.
- R5: The update latches load from the flip-flops only at a rising edge with the update strobe active (upd_en while idle, the sequencer's update step while busy). Through all other shift and capture activity they hold.
- R6: While rst_n is 0, all flip-flops and latches clear to 0 and the effective mode is normal, so pin_out equals pin_in and so is 0 even with test_mode at 1.
- R7: A seq_start accepted while idle makes seq_done high for one cycle, starting at the (N+2)th rising edge after the accepting edge. seq_resp then holds the responses captured by the previous run, with bit i taken from cell i. After reset, the first run reports all zeros.
- R8: During a run, pin_out keeps the previously applied vector through the whole shift step. From the update step onward it shows seq_vec, with bit i on pin_out[i].
- R9: While seq_busy is 1, scan_en, cap_en, upd_en, si and test_mode have no effect on the run's outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Output multiplexer select when idle: 1 drives latches |
| scan_en | input | 1 | Shift enable for the flip-flop chain |
| cap_en | input | 1 | Capture clock enable (when not shifting) |
| upd_en | input | 1 | Update strobe: latches load from flip-flops |
| si | input | 1 | Serial scan input into cell 0 |
| so | output | 1 | Serial scan output from cell N-1 |
| pin_in | input | N | Parallel inputs |
| pin_out | output | N | Parallel outputs |
| seq_start | input | 1 | Starts one sequencer test cycle |
| seq_vec | input | N | Test vector to apply in that cycle |
| seq_busy | output | 1 | Sequencer run in progress |
| seq_done | output | 1 | One-cycle pulse: seq_resp valid |
| seq_resp | output | N | Responses of the previous run |

## Verification
In the first phase, random mixes of shift, capture, update and mode run against a cycle model. Serial data, pin data and strobe timing all vary, which exposes wrong shift direction, capture priority and latch leakage. A walking single one entered after a zero flush shows whether the chain length is exactly N. Next comes a steady-latch pattern, where shifts and captures run behind a fixed applied vector. This separates a true hold stage from a design that drives the shift flip-flops straight to the pins. Sequencer runs use pin inputs that loop back from the outputs through a changing fault mask. The reported responses are therefore unique to the previous vector, which tells correct one-run lag apart from stale or same-run data. Random raw-control noise during each run shows that the sequencer owns the chain while busy.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_mode,
  input  logic         scan_en,
  input  logic         cap_en,
  input  logic         upd_en,
  input  logic         si,
  output logic         so,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  input  logic         seq_start,
  input  logic [N-1:0] seq_vec,
  output logic         seq_busy,
  output logic         seq_done,
  output logic [N-1:0] seq_resp
);
  localparam int CW = $clog2(N + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_UPD, S_CAP, S_DONE} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [N-1:0] cs_q, lat_q, vec_q, resp_q, resp_nx;
  logic         do_shift, do_cap, do_upd, ser_in, mode_eff;

  assign seq_busy = (st != S_IDLE);
  assign seq_done = (st == S_DONE);
  assign seq_resp = resp_q;

  assign do_shift = seq_busy ? (st == S_SHIFT) : scan_en;
  assign do_cap   = seq_busy ? (st == S_CAP)   : (cap_en & ~scan_en);
  assign do_upd   = seq_busy ? (st == S_UPD)   : upd_en;
  assign ser_in   = seq_busy ? vec_q[N-1]      : si;
  assign mode_eff = rst_n & (seq_busy | test_mode);

  assign pin_out = mode_eff ? lat_q : pin_in;
  assign so      = cs_q[N-1];

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic chain_in;
    if (i == 0) begin : g_head
      assign chain_in = ser_in;
    end else begin : g_body
      assign chain_in = cs_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cs_q[i]  <= 1'b0;
        lat_q[i] <= 1'b0;
      end else begin
        if (do_shift)    cs_q[i] <= chain_in;
        else if (do_cap) cs_q[i] <= pin_in[i];
        if (do_upd)      lat_q[i] <= cs_q[i];
      end
    end
  end

  always_comb begin
    resp_nx    = resp_q << 1;
    resp_nx[0] = so;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      vec_q  <= '0;
      resp_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (seq_start) begin
          st    <= S_SHIFT;
          cnt   <= '0;
          vec_q <= seq_vec;
        end
        S_SHIFT: begin
          vec_q  <= vec_q << 1;
          resp_q <= resp_nx;
          cnt    <= cnt + 1'b1;
          if (cnt == CW'(N - 1)) st <= S_UPD;
        end
        S_UPD:   st <= S_CAP;
        S_CAP:   st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         test_mode,
  input logic         scan_en,
  input logic         cap_en,
  input logic         upd_en,
  input logic         so,
  input logic [N-1:0] pin_in,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] lat_q,
  input logic         seq_start,
  input logic         seq_busy,
  input logic         seq_done
);
  // R1
  normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !test_mode) |-> pin_out == pin_in);

  // R2
  test_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy || test_mode) |-> pin_out == lat_q);

  // R3
  capture_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !scan_en && cap_en) |=> so == $past(pin_in[N-1]));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !scan_en && !cap_en) |=> $stable(so));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !upd_en) |=> $stable(lat_q));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  // R7
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && !seq_busy) |=> seq_busy);
endmodule

bind bscan_chain bscan_chain_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
  .cap_en(cap_en), .upd_en(upd_en), .so(so), .pin_in(pin_in),
  .pin_out(pin_out), .lat_q(lat_q), .seq_start(seq_start),
  .seq_busy(seq_busy), .seq_done(seq_done)
);

// File: tb/sim_bscan_chain.sv
`timescale 1ns/1ps
module sim_bscan_chain;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic test_mode = 0, scan_en = 0, cap_en = 0, upd_en = 0, si = 0, seq_start = 0;
  logic [N-1:0] pin_in = '0, seq_vec = '0;
  logic so, seq_busy, seq_done;
  logic [N-1:0] pin_out, seq_resp;

  int total = 0, bad = 0;
  bit loop_on = 0;
  logic [N-1:0] flt = '0;
  logic [N-1:0] m_ff, m_lat;

  bscan_chain #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
    .cap_en(cap_en), .upd_en(upd_en), .si(si), .so(so), .pin_in(pin_in),
    .pin_out(pin_out), .seq_start(seq_start), .seq_vec(seq_vec),
    .seq_busy(seq_busy), .seq_done(seq_done), .seq_resp(seq_resp)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (loop_on && seq_busy) pin_in <= pin_out ^ flt;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] ff_next(input logic [N-1:0] ff, input logic sh,
                                           input logic cp, input logic s, input logic [N-1:0] pi);
    if (sh) return (ff << 1) | N'(s);
    if (cp) return pi;
    return ff;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] vec, prev_vec, prev_flt, exp_resp, n_ff;
    int unsigned seed;
    int cyc;
    seed = $urandom(7);

    pin_in = 8'hA5; test_mode = 1;
    #5;
    chk("R6 pin_out in reset", pin_out, pin_in);
    chk("R6 so in reset", so, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 latches cleared", pin_out, 0);
    m_ff = '0; m_lat = '0;

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      chk(test_mode ? "R2 R5 pin_out" : "R1 pin_out", pin_out, test_mode ? m_lat : pin_in);
      chk("R3 R4 so", so, m_ff[N-1]);
      scan_en   = ($urandom % 3) == 0;
      cap_en    = ($urandom % 2) == 0;
      upd_en    = ($urandom % 4) == 0;
      si        = $urandom;
      test_mode = $urandom;
      pin_in    = N'($urandom);
      n_ff  = ff_next(m_ff, scan_en, cap_en, si, pin_in);
      m_lat = upd_en ? m_ff : m_lat;
      m_ff  = n_ff;
    end

    @(negedge clk);
    cap_en = 0; upd_en = 0; scan_en = 1; si = 0; test_mode = 0;
    repeat (N) @(negedge clk);
    si = 1;
    for (int j = 1; j <= N; j++) begin
      @(negedge clk);
      si = 0;
      chk("R4 walking one on so", so, (j == N));
    end
    scan_en = 0; upd_en = 1; test_mode = 1;
    @(negedge clk);
    upd_en = 0;
    chk("R5 update loads latches", pin_out, 64'h1 << (N - 1));
    for (int j = 0; j < 2 * N; j++) begin
      scan_en = $urandom; cap_en = $urandom; si = $urandom; pin_in = N'($urandom);
      @(negedge clk);
      chk("R5 latch holds", pin_out, 64'h1 << (N - 1));
    end
    scan_en = 0; cap_en = 0; test_mode = 0;

    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    prev_vec = '0; prev_flt = '0;
    for (int k = 0; k < 6; k++) begin
      vec = N'($urandom);
      flt = (k == 0) ? '0 : N'($urandom);
      @(negedge clk);
      seq_vec = vec; seq_start = 1; loop_on = 1;
      cyc = 0;
      do begin
        @(negedge clk);
        cyc++;
        seq_start = 0;
        if (!seq_done) begin
          if (cyc <= N + 1) chk("R8 previous vector held", pin_out, prev_vec);
          scan_en = $urandom; cap_en = $urandom; upd_en = $urandom;
          si = $urandom; test_mode = $urandom;
        end
      end while (!seq_done && cyc < 50);
      scan_en = 0; cap_en = 0; upd_en = 0; si = 0; test_mode = 0;
      exp_resp = prev_vec ^ prev_flt;
      chk("R7 done latency", cyc, N + 3);
      chk("R7 R9 responses", seq_resp, exp_resp);
      chk("R8 vector applied", pin_out, vec);
      prev_vec = vec; prev_flt = flt;
      @(negedge clk);
      chk("R7 done one cycle", seq_done, 0);
    end
    loop_on = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule